// File: doc/BRIEF.md
# Hot-plug slot power sequencer

This block runs one hot-pluggable expansion slot on behalf of a host. The host asks for the slot to go on or off, and for the attention indicator to be normal or lit, through a one-cycle command strobe. The block drives the slot's power enable, the bus isolation switch, the slot reset and the two indicators. Before it applies power it checks the inserted board. The board must be present, carry no power fault, suit the segment clock and fit inside the remaining power budget. If any check fails, the request is refused with a completion code and the slot is left dark.

A successful turn-on runs as a fixed interlocked sequence. Power comes first. Then the reset is released and the bus is linked in the same step. Turn-off runs the mirror image of that sequence. Each step holds for a programmable number of cycles. While a sequence runs, a busy flag stays high, and the end of every request is marked by a single-cycle done strobe that carries the status. The board's asynchronous signals (the two presence-detect lines, the 66 MHz capability line and the fault line) are synchronised first. A continuously driven query group reports the slot state, the decoded power class, the board and segment frequencies, and a one-cycle notice of unsolicited changes.

Top module: `hps_slot_seq`

## Requirements
- R1: After reset, and whenever the slot is off and idle, slot power is disabled, the bus link is open, the slot reset is asserted (`slot_rst_n` low), the state indicator is dark and busy is low.
- R2: After SYNC_STAGES cycles of synchronisation, `pres_det_n` decodes onto `q_pwr_class` as follows. 2'b11 gives 0 (not present), 2'b10 gives 1 (low), 2'b01 gives 2 (medium) and 2'b00 gives 3 (high).
- R3: On an accepted turn-on, `slot_pwr_en` rises in the cycle after the command. Reset release and bus link follow together step_cycles+1 cycles later. Done with status 0 and the lit state indicator follow after a further step_cycles+1 cycles.
- R4: On an accepted turn-off, the reset is asserted and the bus link is opened together in the cycle after the command. Power is removed step_cycles+1 cycles later. Done with status 0 and the dark state indicator follow after a further step_cycles+1 cycles.
- R5: If the segment runs at 66 MHz (`seg_66`=1) and the board reports 33 MHz only (`cap66_in`=0), a turn-on is refused with status 1. Done appears in the cycle after the command and the slot stays off.
- R6: If the board power class is greater than `pwr_budget`, a turn-on is refused with status 2 and the slot stays off.
- R7: A power fault seen while the slot is powered removes power, link and reset release in the next cycle. If a sequence is in progress, it ends with done and status 3. A turn-on requested while a fault is present is refused with status 3.
- R8: A turn-on with no board present is refused with status 4 (general failure). The checks take priority in this order: fault (3), absent (4), frequency (1), power budget (2).
- R9: Every accepted command loads `cmd_attn` into `attn_led`, including commands that are refused.
- R10: `busy` is high for the whole of a sequence. Commands given while busy are ignored and change neither the indicators nor the sequence.
- R11: `done` is a one-cycle strobe. A turn-on while already on, or a turn-off while already off, completes with done and status 0 in the next cycle and leaves the slot outputs unchanged.
- R12: `status_chg` pulses for one cycle when the decoded power class changes, or when a fault rises, while the block is idle and no command is presented. It pulses in the cycle after the synchronised change.
- R13: `q_slot_on` shows the on state, `q_board_66` shows the synchronised capability input, and `q_seg_66` shows the segment frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle request strobe |
| cmd_on | input | 1 | Requested slot state: 1 on, 0 off |
| cmd_attn | input | 1 | Requested attention indicator: 1 attention, 0 normal |
| step_cycles | input | WAIT_W | Extra hold cycles per sequencing step |
| pwr_budget | input | 2 | Highest power class still allowed |
| seg_66 | input | 1 | Segment runs at 66 MHz |
| pres_det_n | input | 2 | Presence-detect pair, active low |
| cap66_in | input | 1 | Board supports 66 MHz |
| pwr_fault | input | 1 | Slot short-circuit indication |
| slot_pwr_en | output | 1 | Slot power enable |
| bus_link_en | output | 1 | Bus isolation switch closed |
| slot_rst_n | output | 1 | Slot reset, active low |
| attn_led | output | 1 | Attention indicator |
| state_led | output | 1 | Slot state indicator |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Request completion strobe |
| done_status | output | 3 | Completion code, valid with done |
| status_chg | output | 1 | Unsolicited change notice |
| q_slot_on | output | 1 | Query: slot is on |
| q_pwr_class | output | 2 | Query: board power class |
| q_board_66 | output | 1 | Query: board 66 MHz capable |
| q_seg_66 | output | 1 | Query: segment frequency is 66 MHz |

## Verification
The hardest situation to reach is a fault that lands in the middle of a power-up step. The fault has to pass the synchroniser while the sequencer is still busy, so it must be driven in the cycle right after the command is accepted. Only then does the abort arrive before the link step. The bench sets the fault line immediately after the command strobe and checks that power, link and reset release all drop together three cycles later, with status 3 on done. It also checks that no change notice is raised, since a sequence was pending.

// File: rtl/hps_pkg.sv
package hps_pkg;

   typedef enum logic [2:0] {
      ST_OK           = 3'd0,
      ST_WRONG_FREQ   = 3'd1,
      ST_NO_POWER     = 3'd2,
      ST_POWER_FAIL   = 3'd3,
      ST_GENERAL_FAIL = 3'd4
   } done_code_e;

   typedef enum logic [1:0] {
      CLS_NONE = 2'd0,
      CLS_LOW  = 2'd1,
      CLS_MED  = 2'd2,
      CLS_HIGH = 2'd3
   } pwr_class_e;

   typedef enum logic [2:0] {
      SQ_OFF,
      SQ_PWR_UP,
      SQ_LINK,
      SQ_ON,
      SQ_UNLINK,
      SQ_PWR_DN
   } seq_state_e;

   // presence pair is active low; both high means empty slot
   function automatic pwr_class_e decode_class(input logic [1:0] pd_n);
      case (pd_n)
         2'b11:   return CLS_NONE;
         2'b10:   return CLS_LOW;
         2'b01:   return CLS_MED;
         default: return CLS_HIGH;
      endcase
   endfunction

endpackage

// File: rtl/hps_in_sync.sv
module hps_in_sync #(
   parameter int             W       = 4,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("hps_in_sync: W must be at least 1");
   end
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("hps_in_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_bypass
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
         end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
               pipe[i] <= pipe[i-1];
            end
         end
      end
      assign q = pipe[STAGES-1];
   end

endmodule

// File: rtl/hps_board_check.sv
module hps_board_check
   import hps_pkg::*;
(
   input  logic [1:0]  pd_n,
   input  logic        cap66,
   input  logic        fault,
   input  logic        seg_66,
   input  logic [1:0]  budget,
   output pwr_class_e  cls,
   output done_code_e  verdict
);

   always_comb begin
      cls = decode_class(pd_n);
      // fixed priority: fault, absence, frequency, budget
      if (fault) begin
         verdict = ST_POWER_FAIL;
      end else if (cls == CLS_NONE) begin
         verdict = ST_GENERAL_FAIL;
      end else if (seg_66 && !cap66) begin
         verdict = ST_WRONG_FREQ;
      end else if (cls > budget) begin
         verdict = ST_NO_POWER;
      end else begin
         verdict = ST_OK;
      end
   end

endmodule

// File: rtl/hps_seq_fsm.sv
module hps_seq_fsm
   import hps_pkg::*;
#(
   parameter int WAIT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_on,
   input  logic              cmd_attn,
   input  logic [WAIT_W-1:0] step_cycles,
   input  done_code_e        verdict,
   input  pwr_class_e        cls,
   input  logic              fault,
   output logic              pwr_en,
   output logic              link_en,
   output logic              slot_rst_n,
   output logic              busy,
   output logic              on_state,
   output logic              attn,
   output logic              done,
   output done_code_e        status,
   output logic              chg
);

   seq_state_e        st;
   logic [WAIT_W-1:0] cnt;
   pwr_class_e        cls_prev;
   logic              flt_prev;
   logic              idle;
   logic              step_end;

   assign idle     = (st == SQ_OFF) || (st == SQ_ON);
   assign busy     = !idle;
   assign step_end = (cnt == '0);

   assign pwr_en     = (st == SQ_PWR_UP) || (st == SQ_LINK) || (st == SQ_ON) || (st == SQ_UNLINK);
   assign link_en    = (st == SQ_LINK) || (st == SQ_ON);
   assign slot_rst_n = link_en;
   assign on_state   = (st == SQ_ON);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= SQ_OFF;
         cnt      <= '0;
         attn     <= 1'b0;
         done     <= 1'b0;
         status   <= ST_OK;
         chg      <= 1'b0;
         cls_prev <= CLS_NONE;
         flt_prev <= 1'b0;
      end else begin
         done     <= 1'b0;
         chg      <= idle && !cmd_valid && ((cls != cls_prev) || (fault && !flt_prev));
         cls_prev <= cls;
         flt_prev <= fault;
         if (fault && (st != SQ_OFF)) begin
            // short on a powered slot: drop everything at once
            st  <= SQ_OFF;
            cnt <= '0;
            if (busy) begin
               done   <= 1'b1;
               status <= ST_POWER_FAIL;
            end
         end else begin
            case (st)
               SQ_OFF: begin
                  if (cmd_valid) begin
                     attn <= cmd_attn;
                     if (cmd_on && (verdict == ST_OK)) begin
                        st  <= SQ_PWR_UP;
                        cnt <= step_cycles;
                     end else begin
                        done   <= 1'b1;
                        status <= cmd_on ? verdict : ST_OK;
                     end
                  end
               end
               SQ_ON: begin
                  if (cmd_valid) begin
                     attn <= cmd_attn;
                     if (!cmd_on) begin
                        st  <= SQ_UNLINK;
                        cnt <= step_cycles;
                     end else begin
                        done   <= 1'b1;
                        status <= ST_OK;
                     end
                  end
               end
               SQ_PWR_UP: begin
                  if (step_end) begin
                     st  <= SQ_LINK;
                     cnt <= step_cycles;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               SQ_LINK: begin
                  if (step_end) begin
                     st     <= SQ_ON;
                     done   <= 1'b1;
                     status <= ST_OK;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               SQ_UNLINK: begin
                  if (step_end) begin
                     st  <= SQ_PWR_DN;
                     cnt <= step_cycles;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               SQ_PWR_DN: begin
                  if (step_end) begin
                     st     <= SQ_OFF;
                     done   <= 1'b1;
                     status <= ST_OK;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               default: st <= SQ_OFF;
            endcase
         end
      end
   end

   // R3: the link never closes on an unpowered slot
   a_r3_power_before_link: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_en) |-> ($past(pwr_en) && pwr_en));

   // R4: power is only dropped after the link opened, unless a fault forced it
   a_r4_unlink_before_power: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pwr_en) && !$past(fault)) |-> !$past(link_en));

   // R5: a refused request leaves the slot unpowered
   a_r5_refusal_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (status != ST_OK)) |-> !pwr_en);

   // R7: a fault removes power on the following cycle
   a_r7_fault_kills_power: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !pwr_en);

   // R10: completion never overlaps a running sequence
   a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10: commands given while busy leave the attention indicator alone
   a_r10_busy_ignores_attn: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid) |=> $stable(attn));

   // R12: change notice only arises from an idle cycle
   a_r12_chg_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      chg |-> !$past(busy));

endmodule

// File: rtl/hps_slot_seq.sv
module hps_slot_seq
   import hps_pkg::*;
#(
   parameter int WAIT_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_on,
   input  logic              cmd_attn,
   input  logic [WAIT_W-1:0] step_cycles,
   input  logic [1:0]        pwr_budget,
   input  logic              seg_66,
   input  logic [1:0]        pres_det_n,
   input  logic              cap66_in,
   input  logic              pwr_fault,
   output logic              slot_pwr_en,
   output logic              bus_link_en,
   output logic              slot_rst_n,
   output logic              attn_led,
   output logic              state_led,
   output logic              busy,
   output logic              done,
   output logic [2:0]        done_status,
   output logic              status_chg,
   output logic              q_slot_on,
   output logic [1:0]        q_pwr_class,
   output logic              q_board_66,
   output logic              q_seg_66
);

   localparam int           SYNC_W   = 4;
   localparam logic [3:0]   SYNC_RST = 4'b1100;   // empty slot, 33 MHz, no fault

   if (WAIT_W < 1 || WAIT_W > 32) begin : g_bad_wait
      $error("hps_slot_seq: WAIT_W must be 1..32");
   end

   logic [SYNC_W-1:0] raw_in;
   logic [SYNC_W-1:0] syn_in;
   logic [1:0]        pd_s;
   logic              cap_s;
   logic              flt_s;
   pwr_class_e        cls;
   done_code_e        verdict;
   done_code_e        status;
   logic              on_state;

   assign raw_in = {pres_det_n, cap66_in, pwr_fault};
   assign pd_s   = syn_in[3:2];
   assign cap_s  = syn_in[1];
   assign flt_s  = syn_in[0];

   hps_in_sync #(
      .W       (SYNC_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   hps_board_check u_check (
      .pd_n    (pd_s),
      .cap66   (cap_s),
      .fault   (flt_s),
      .seg_66  (seg_66),
      .budget  (pwr_budget),
      .cls     (cls),
      .verdict (verdict)
   );

   hps_seq_fsm #(
      .WAIT_W (WAIT_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_on      (cmd_on),
      .cmd_attn    (cmd_attn),
      .step_cycles (step_cycles),
      .verdict     (verdict),
      .cls         (cls),
      .fault       (flt_s),
      .pwr_en      (slot_pwr_en),
      .link_en     (bus_link_en),
      .slot_rst_n  (slot_rst_n),
      .busy        (busy),
      .on_state    (on_state),
      .attn        (attn_led),
      .done        (done),
      .status      (status),
      .chg         (status_chg)
   );

   assign done_status = status;
   assign state_led   = on_state;
   assign q_slot_on   = on_state;
   assign q_pwr_class = cls;
   assign q_board_66  = cap_s;
   assign q_seg_66    = seg_66;

endmodule

// File: tb/hps_slot_seq_tb_top.sv
`timescale 1ns/1ps
module hps_slot_seq_tb_top;

   localparam int WAIT_W = 8;
   localparam int SYNC   = 2;
   localparam int STEP   = 3;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cmd_valid, cmd_on, cmd_attn;
   logic [WAIT_W-1:0] step_cycles;
   logic [1:0]        pwr_budget;
   logic              seg_66;
   logic [1:0]        pres_det_n;
   logic              cap66_in, pwr_fault;
   logic              slot_pwr_en, bus_link_en, slot_rst_n, attn_led, state_led;
   logic              busy, done, status_chg, q_slot_on, q_board_66, q_seg_66;
   logic [2:0]        done_status;
   logic [1:0]        q_pwr_class;

   always #2.5 clk = ~clk;

   hps_slot_seq #(.WAIT_W(WAIT_W), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_on(cmd_on),
      .cmd_attn(cmd_attn), .step_cycles(step_cycles), .pwr_budget(pwr_budget),
      .seg_66(seg_66), .pres_det_n(pres_det_n), .cap66_in(cap66_in),
      .pwr_fault(pwr_fault), .slot_pwr_en(slot_pwr_en), .bus_link_en(bus_link_en),
      .slot_rst_n(slot_rst_n), .attn_led(attn_led), .state_led(state_led),
      .busy(busy), .done(done), .done_status(done_status), .status_chg(status_chg),
      .q_slot_on(q_slot_on), .q_pwr_class(q_pwr_class), .q_board_66(q_board_66),
      .q_seg_66(q_seg_66));

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wrap_up();
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // ---------------- behavioural reference model ----------------
   // phases: 0 off, 1 powering, 2 linking, 3 on, 4 unlinking, 5 powering down
   int         m_phase, m_hold, m_status, m_prev_cls;
   bit         m_done, m_attn, m_chg, m_prev_flt;
   logic [3:0] m_hist[$];

   function automatic int cls_of(input logic [1:0] p);
      if (p == 2'b11) return 0;
      if (p == 2'b10) return 1;
      if (p == 2'b01) return 2;
      return 3;
   endfunction

   always @(posedge clk) begin
      logic [3:0] seen;
      int         c;
      int         code;
      bit         f, idle_now, nchg;
      if (!rst_n) begin
         m_phase = 0; m_hold = 0; m_status = 0; m_prev_cls = 0;
         m_done = 0; m_attn = 0; m_chg = 0; m_prev_flt = 0;
         m_hist.delete();
      end else begin
         if (SYNC == 0) seen = {pres_det_n, cap66_in, pwr_fault};
         else if (m_hist.size() == SYNC) seen = m_hist[0];
         else seen = 4'b1100;
         c = cls_of(seen[3:2]);
         f = seen[0];
         if (f) code = 3;
         else if (c == 0) code = 4;
         else if (seg_66 && !seen[1]) code = 1;
         else if (c > int'(pwr_budget)) code = 2;
         else code = 0;
         idle_now = (m_phase == 0) || (m_phase == 3);
         nchg = idle_now && !cmd_valid && ((c != m_prev_cls) || (f && !m_prev_flt));
         m_prev_cls = c;
         m_prev_flt = f;
         m_done = 0;
         if (f && m_phase != 0) begin
            if (!idle_now) begin m_done = 1; m_status = 3; end
            m_phase = 0;
            m_hold = 0;
         end else if (m_phase == 0) begin
            if (cmd_valid) begin
               m_attn = cmd_attn;
               if (cmd_on && code == 0) begin m_phase = 1; m_hold = int'(step_cycles); end
               else begin m_done = 1; m_status = cmd_on ? code : 0; end
            end
         end else if (m_phase == 3) begin
            if (cmd_valid) begin
               m_attn = cmd_attn;
               if (!cmd_on) begin m_phase = 4; m_hold = int'(step_cycles); end
               else begin m_done = 1; m_status = 0; end
            end
         end else if (m_hold > 0) begin
            m_hold--;
         end else begin
            if (m_phase == 1) begin m_phase = 2; m_hold = int'(step_cycles); end
            else if (m_phase == 4) begin m_phase = 5; m_hold = int'(step_cycles); end
            else begin
               m_phase = (m_phase == 2) ? 3 : 0;
               m_done = 1;
               m_status = 0;
            end
         end
         m_chg = nchg;
         if (SYNC > 0) begin
            m_hist.push_back({pres_det_n, cap66_in, pwr_fault});
            if (m_hist.size() > SYNC) void'(m_hist.pop_front());
         end
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      int  e_cls;
      bit  e_cap, bad;
      if (rst_n && !finished) begin
         if (SYNC == 0) begin e_cls = cls_of(pres_det_n); e_cap = cap66_in; end
         else if (m_hist.size() == SYNC) begin e_cls = cls_of(m_hist[0][3:2]); e_cap = m_hist[0][1]; end
         else begin e_cls = 0; e_cap = 0; end
         bad = 0;
         checks++;
         if (slot_pwr_en != (m_phase inside {1, 2, 3, 4})) begin bad = 1;
            $display("FAIL R3/R4 model pwr actual=%0d expected=%0d", slot_pwr_en, m_phase inside {1, 2, 3, 4}); end
         if (bus_link_en != (m_phase inside {2, 3}) || slot_rst_n != (m_phase inside {2, 3})) begin bad = 1;
            $display("FAIL R3/R4 model link actual=%0d expected=%0d", bus_link_en, m_phase inside {2, 3}); end
         if (busy != (m_phase inside {1, 2, 4, 5})) begin bad = 1;
            $display("FAIL R10 model busy actual=%0d expected=%0d", busy, m_phase inside {1, 2, 4, 5}); end
         if (state_led != (m_phase == 3) || q_slot_on != (m_phase == 3)) begin bad = 1;
            $display("FAIL R13 model on actual=%0d expected=%0d", q_slot_on, m_phase == 3); end
         if (done != m_done || int'(done_status) != m_status) begin bad = 1;
            $display("FAIL R11 model done/status actual=%0d/%0d expected=%0d/%0d", done, done_status, m_done, m_status); end
         if (attn_led != m_attn) begin bad = 1;
            $display("FAIL R9 model attn actual=%0d expected=%0d", attn_led, m_attn); end
         if (status_chg != m_chg) begin bad = 1;
            $display("FAIL R12 model chg actual=%0d expected=%0d", status_chg, m_chg); end
         if (int'(q_pwr_class) != e_cls || q_board_66 != e_cap || q_seg_66 != seg_66) begin bad = 1;
            $display("FAIL R2/R13 model query actual=%0d expected=%0d", q_pwr_class, e_cls); end
         if (bad) fails++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic send_cmd(input bit on, input bit at);
      @(negedge clk); #1;
      cmd_valid = 1'b1; cmd_on = on; cmd_attn = at;
      @(negedge clk); #1;
      cmd_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         wrap_up();
      end
   end

   initial begin
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_on = 1'b0; cmd_attn = 1'b0;
      step_cycles = WAIT_W'(STEP); pwr_budget = 2'd3; seg_66 = 1'b0;
      pres_det_n = 2'b11; cap66_in = 1'b0; pwr_fault = 1'b0;
      wait_n(4);
      rst_n = 1'b1;
      wait_n(4);
      chk("R1 reset pwr", slot_pwr_en, 0);
      chk("R1 reset link", bus_link_en, 0);
      chk("R1 reset slot_rst_n", slot_rst_n, 0);
      chk("R1 reset state_led", state_led, 0);
      chk("R1 reset busy", busy, 0);

      // presence decode and change notice
      pres_det_n = 2'b10;
      wait_n(2);
      chk("R2 class low", q_pwr_class, 1);
      chk("R12 chg not yet", status_chg, 0);
      wait_n(1);
      chk("R12 chg pulse", status_chg, 1);
      wait_n(1);
      chk("R12 chg one cycle", status_chg, 0);
      pres_det_n = 2'b01;
      wait_n(3);
      chk("R2 class medium", q_pwr_class, 2);
      pres_det_n = 2'b00; cap66_in = 1'b1;
      wait_n(3);
      chk("R2 class high", q_pwr_class, 3);
      chk("R13 board 66", q_board_66, 1);
      wait_n(2);

      // interlocked turn-on, with an ignored command while busy
      send_cmd(1, 1);
      chk("R3 power first", slot_pwr_en, 1);
      chk("R3 link still open", bus_link_en, 0);
      chk("R3 reset still held", slot_rst_n, 0);
      chk("R10 busy during power-up", busy, 1);
      chk("R9 attention set", attn_led, 1);
      send_cmd(0, 0);
      chk("R10 busy command ignored attn", attn_led, 1);
      chk("R10 busy command ignored link", bus_link_en, 0);
      wait_n(1);
      chk("R3 link at step end minus one", bus_link_en, 0);
      wait_n(1);
      chk("R3 link closed", bus_link_en, 1);
      chk("R3 reset released", slot_rst_n, 1);
      chk("R3 power kept", slot_pwr_en, 1);
      wait_n(3);
      chk("R3 no early done", done, 0);
      chk("R3 state dark before end", state_led, 0);
      wait_n(1);
      chk("R3 done", done, 1);
      chk("R3 status ok", done_status, 0);
      chk("R3 state lit", state_led, 1);
      chk("R13 query on", q_slot_on, 1);
      chk("R10 busy cleared", busy, 0);
      wait_n(1);
      chk("R11 done one cycle", done, 0);

      // redundant turn-on
      send_cmd(1, 0);
      chk("R11 redundant on done", done, 1);
      chk("R11 redundant on status", done_status, 0);
      chk("R11 redundant on keeps link", bus_link_en, 1);
      chk("R9 attention normal", attn_led, 0);

      // interlocked turn-off
      send_cmd(0, 0);
      chk("R4 link opened first", bus_link_en, 0);
      chk("R4 reset asserted first", slot_rst_n, 0);
      chk("R4 power kept", slot_pwr_en, 1);
      wait_n(3);
      chk("R4 power still on", slot_pwr_en, 1);
      wait_n(1);
      chk("R4 power removed", slot_pwr_en, 0);
      wait_n(4);
      chk("R4 done", done, 1);
      chk("R4 status ok", done_status, 0);
      chk("R4 state dark", state_led, 0);

      // redundant turn-off
      send_cmd(0, 1);
      chk("R11 redundant off done", done, 1);
      chk("R11 redundant off stays off", slot_pwr_en, 0);
      chk("R9 attention on off command", attn_led, 1);

      // wrong frequency
      seg_66 = 1'b1; cap66_in = 1'b0;
      wait_n(4);
      chk("R13 segment 66", q_seg_66, 1);
      chk("R13 board 33", q_board_66, 0);
      send_cmd(1, 0);
      chk("R5 wrong freq done", done, 1);
      chk("R5 wrong freq status", done_status, 1);
      chk("R9 attention on refusal", attn_led, 0);
      wait_n(2);
      chk("R5 stays off", slot_pwr_en, 0);

      // insufficient power budget
      cap66_in = 1'b1; pwr_budget = 2'd1;
      wait_n(4);
      send_cmd(1, 1);
      chk("R6 budget status", done_status, 2);
      chk("R6 budget stays off", slot_pwr_en, 0);
      pwr_budget = 2'd3;

      // absent board, also outranking a frequency mismatch
      pres_det_n = 2'b11; cap66_in = 1'b0;
      wait_n(4);
      send_cmd(1, 0);
      chk("R8 absent status", done_status, 4);
      chk("R8 absent done", done, 1);
      pres_det_n = 2'b00; cap66_in = 1'b1; seg_66 = 1'b0;
      wait_n(4);

      // fault present at request
      pwr_fault = 1'b1;
      wait_n(4);
      send_cmd(1, 0);
      chk("R7 fault at request status", done_status, 3);
      chk("R7 fault at request off", slot_pwr_en, 0);
      pwr_fault = 1'b0;
      wait_n(4);

      // fault in the middle of power-up
      send_cmd(1, 1);
      pwr_fault = 1'b1;
      chk("R7 powering before fault", slot_pwr_en, 1);
      wait_n(3);
      chk("R7 abort power", slot_pwr_en, 0);
      chk("R7 abort link", bus_link_en, 0);
      chk("R7 abort done", done, 1);
      chk("R7 abort status", done_status, 3);
      chk("R12 no notice while pending", status_chg, 0);
      pwr_fault = 1'b0;
      wait_n(4);

      // fault on a running slot
      send_cmd(1, 0);
      wait_n(10);
      chk("R3 on before fault", q_slot_on, 1);
      pwr_fault = 1'b1;
      wait_n(2);
      chk("R7 power before sync", slot_pwr_en, 1);
      wait_n(1);
      chk("R7 running fault power", slot_pwr_en, 0);
      chk("R7 running fault reset", slot_rst_n, 0);
      chk("R12 running fault notice", status_chg, 1);
      chk("R7 no done when idle", done, 0);
      pwr_fault = 1'b0;
      wait_n(4);

      // shortest steps
      step_cycles = '0;
      send_cmd(1, 0);
      chk("R3 zero-step power", slot_pwr_en, 1);
      chk("R3 zero-step link open", bus_link_en, 0);
      wait_n(1);
      chk("R3 zero-step link", bus_link_en, 1);
      wait_n(1);
      chk("R3 zero-step done", done, 1);
      send_cmd(0, 0);
      wait_n(2);
      chk("R4 zero-step done", done, 1);
      chk("R4 zero-step off", slot_pwr_en, 0);
      wait_n(3);

      wrap_up();
   end

endmodule